// File: doc/BRIEF.md
# Descriptor-Chained XOR Copy Engine

This block is one channel of a memory-to-memory offload engine. Software builds a linked list of descriptors in memory, loads the address of the first one into the channel's next-descriptor register and writes the activation bit. The channel then walks the list on its own. For each descriptor it fetches the header, moves or combines the data one word at a time, marks the descriptor done in memory and follows the next pointer. A zero pointer ends the walk.

There are two operation modes. In copy mode each destination word is taken from source 0. In XOR mode each destination word is the XOR of the sources whose enable bits are set in the descriptor's command word. The mode is a channel setting that is captured at activation, so one mode applies to the whole chain.

The memory side is a word-wide request/response port that has one access outstanding at a time. An error flag on any response aborts the chain and leaves the failing address in a register. Two single-cycle pulses report the end of each descriptor and the end of the chain.

Top module: `xce_chan`

## Requirements
- R1: Writing register 0 with bit 0 set while the channel is idle starts the walk at the address held in register 1 (next descriptor). A write to register 0 with bit 0 clear has no effect.
- R2: Reading register 0 returns the channel state in bits [5:4]: 1 while active, 0 when idle. All register reads return their data on `reg_rdata` one clock after `reg_addr` is presented.
- R3: A descriptor is thirteen 32-bit words at byte offsets from its base: status +0, command +4, next pointer +8, byte count +12, destination +16, and source i at +20+4*i. Command bit 31 must be set. When it is clear, the chain aborts before any data access, and the descriptor base is recorded as the error address.
- R4: With register 3 bit 0 clear (copy mode), destination word k equals source 0 word k for every word in the byte count, whatever the enable bits hold.
- R5: With register 3 bit 0 set (XOR mode), destination word k is the XOR of word k of every source i whose command bit i is set. When no source is enabled, zero is written.
- R6: After the last data word of a descriptor, the engine writes 0x8000_0000 to that descriptor's status word. It then raises `eod_pulse` for exactly one cycle.
- R7: A next pointer of zero ends the chain: `eoc_pulse` rises in the same cycle as the final `eod_pulse` and the channel returns to idle. A nonzero pointer continues the walk at that address.
- R8: Register 2 holds the base address of the descriptor being processed or, once idle, the one processed last.
- R9: The mode is sampled at activation. A write to register 3 during a chain takes effect only at the next activation.
- R10: A response with `mem_rerr` set aborts the chain. The byte address of the failing access is recorded in register 4 and the channel goes idle with no status write, no `eod_pulse`, no `eoc_pulse` and no further accesses.
- R11: `mem_req` is a single-cycle pulse. No new request is issued until the response (`mem_rvalid`) to the previous one has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index: 0 control/state, 1 next, 2 current, 3 mode, 4 error address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for `reg_addr` |
| mem_req | output | 1 | Memory request pulse |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_rvalid | input | 1 | Response for the outstanding request |
| mem_rdata | input | 32 | Read data with the response |
| mem_rerr | input | 1 | Response carries an error |
| eod_pulse | output | 1 | One-cycle end-of-descriptor pulse |
| eoc_pulse | output | 1 | One-cycle end-of-chain pulse |

## Verification
The hardest case to reach is an abort in the middle of a descriptor. The bench needs a chain whose data phase is already under way when one specific source read returns an error. The bench's memory model flags a single chosen byte address, the third word of source 0, as faulty. It then checks that the two words before it reached the destination, the rest did not, and the status word stayed clear. The mode latch is reached by writing the mode register straight after activation of a two-descriptor XOR chain. The second descriptor's result then shows which mode was applied. The memory latency alternates between zero and one idle cycles, so every path through the walker is seen under both timings.

// File: rtl/xce_pkg.sv
package xce_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_SRC,
    ST_DST,
    ST_STS
  } walk_t;

  localparam logic [31:0] STATUS_DONE = 32'h8000_0000;

  // register indices
  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_NEXT = 3'd1;
  localparam logic [2:0] RA_CUR  = 3'd2;
  localparam logic [2:0] RA_MODE = 3'd3;
  localparam logic [2:0] RA_ERR  = 3'd4;

  // descriptor word indices
  localparam int unsigned HDR_CMD  = 1;
  localparam int unsigned HDR_NEXT = 2;
  localparam int unsigned HDR_CNT  = 3;
  localparam int unsigned HDR_DST  = 4;
  localparam int unsigned HDR_SRC0 = 5;
endpackage

// File: rtl/xce_first_set.sv
module xce_first_set #(
  parameter int unsigned N = 8,
  localparam int unsigned W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] vec,
  output logic         found,
  output logic [W-1:0] idx
);
  always_comb begin
    found = |vec;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = W'(i);
    end
  end
endmodule

// File: rtl/xce_regs.sv
module xce_regs
  import xce_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  input  logic        busy,
  input  logic [31:0] cur_desc,
  input  logic [31:0] err_addr,
  output logic [31:0] reg_rdata,
  output logic        start,
  output logic [31:0] next_ptr,
  output logic        mode_xor
);
  always_ff @(posedge clk) begin
    if (rst) begin
      start     <= 1'b0;
      next_ptr  <= '0;
      mode_xor  <= 1'b0;
      reg_rdata <= '0;
    end else begin
      start <= reg_wr && (reg_addr == RA_CTRL) && reg_wdata[0] && !busy;
      if (reg_wr && reg_addr == RA_NEXT) next_ptr <= reg_wdata;
      if (reg_wr && reg_addr == RA_MODE) mode_xor <= reg_wdata[0];
      case (reg_addr)
        RA_CTRL: reg_rdata <= {26'd0, 1'b0, busy, 4'd0};
        RA_NEXT: reg_rdata <= next_ptr;
        RA_CUR:  reg_rdata <= cur_desc;
        RA_MODE: reg_rdata <= {31'd0, mode_xor};
        RA_ERR:  reg_rdata <= err_addr;
        default: reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/xce_walker.sv
module xce_walker
  import xce_pkg::*;
#(
  parameter int unsigned NSRC = 8,
  localparam int unsigned SW = $clog2(NSRC),
  localparam int unsigned HLAST = HDR_SRC0 + NSRC - 1,
  localparam int unsigned HW = $clog2(HLAST + 1)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [31:0] start_ptr,
  input  logic        mode_xor,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  input  logic        mem_rerr,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic        eod_pulse,
  output logic        eoc_pulse,
  output logic        busy,
  output logic [31:0] cur_desc,
  output logic [31:0] err_addr
);
  walk_t            st;
  logic             wait_q, mode_q, cmd_ok_q;
  logic [HW-1:0]    hidx;
  logic [NSRC-1:0]  cmd_en_q;
  logic [31:0]      next_q, cnt_q, dst_q, off_q, acc_q;
  logic [31:0]      src_q [NSRC];
  logic [SW-1:0]    sidx_q;

  logic [NSRC-1:0]  en, upto;
  logic             first_found, after_found;
  logic [SW-1:0]    first_idx, after_idx;
  logic [31:0]      req_addr, req_wdata;
  logic             req_we;

  assign en   = mode_q ? cmd_en_q : NSRC'(1);
  assign upto = (NSRC'(2) << sidx_q) - NSRC'(1);

  xce_first_set #(.N(NSRC)) u_first (.vec(en), .found(first_found), .idx(first_idx));
  xce_first_set #(.N(NSRC)) u_after (.vec(en & ~upto), .found(after_found), .idx(after_idx));

  always_comb begin
    req_we    = (st == ST_DST) || (st == ST_STS);
    req_wdata = (st == ST_STS) ? STATUS_DONE : acc_q;
    case (st)
      ST_HDR:  req_addr = cur_desc + (32'(hidx) << 2);
      ST_SRC:  req_addr = src_q[sidx_q] + off_q;
      ST_DST:  req_addr = dst_q + off_q;
      default: req_addr = cur_desc;
    endcase
  end

  assign busy = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE;  wait_q <= 1'b0;  mode_q <= 1'b0;  cmd_ok_q <= 1'b0;
      hidx <= '0;  cmd_en_q <= '0;  next_q <= '0;  cnt_q <= '0;  dst_q <= '0;
      off_q <= '0;  acc_q <= '0;  sidx_q <= '0;  cur_desc <= '0;  err_addr <= '0;
      mem_req <= 1'b0;  mem_we <= 1'b0;  mem_addr <= '0;  mem_wdata <= '0;
      eod_pulse <= 1'b0;  eoc_pulse <= 1'b0;
      for (int i = 0; i < NSRC; i++) src_q[i] <= '0;
    end else begin
      mem_req   <= 1'b0;
      eod_pulse <= 1'b0;
      eoc_pulse <= 1'b0;
      if (st == ST_IDLE) begin
        if (start) begin
          st       <= ST_HDR;
          cur_desc <= start_ptr;
          hidx     <= HW'(HDR_CMD);
          wait_q   <= 1'b0;
          mode_q   <= mode_xor;
        end
      end else if (!wait_q) begin
        mem_req   <= 1'b1;
        mem_addr  <= req_addr;
        mem_we    <= req_we;
        mem_wdata <= req_wdata;
        wait_q    <= 1'b1;
      end else if (mem_rvalid) begin
        wait_q <= 1'b0;
        if (mem_rerr) begin
          err_addr <= mem_addr;
          st       <= ST_IDLE;
        end else begin
          case (st)
            ST_HDR: begin
              if (hidx == HW'(HDR_CMD)) begin
                cmd_ok_q <= mem_rdata[31];
                cmd_en_q <= mem_rdata[NSRC-1:0];
              end
              if (hidx == HW'(HDR_NEXT)) next_q <= mem_rdata;
              if (hidx == HW'(HDR_CNT))  cnt_q  <= mem_rdata;
              if (hidx == HW'(HDR_DST))  dst_q  <= mem_rdata;
              for (int i = 0; i < NSRC; i++) begin
                if (hidx == HW'(HDR_SRC0 + i)) src_q[i] <= mem_rdata;
              end
              if (hidx == HW'(HLAST)) begin
                off_q <= '0;
                acc_q <= '0;
                if (!cmd_ok_q) begin
                  err_addr <= cur_desc;
                  st       <= ST_IDLE;
                end else if (cnt_q == 32'd0) begin
                  st <= ST_STS;
                end else if (first_found) begin
                  st     <= ST_SRC;
                  sidx_q <= first_idx;
                end else begin
                  st <= ST_DST;
                end
              end else begin
                hidx <= hidx + HW'(1);
              end
            end
            ST_SRC: begin
              acc_q <= acc_q ^ mem_rdata;
              if (after_found) sidx_q <= after_idx;
              else             st     <= ST_DST;
            end
            ST_DST: begin
              off_q <= off_q + 32'd4;
              cnt_q <= cnt_q - 32'd4;
              acc_q <= '0;
              if (cnt_q <= 32'd4) begin
                st <= ST_STS;
              end else if (first_found) begin
                st     <= ST_SRC;
                sidx_q <= first_idx;
              end
            end
            default: begin
              eod_pulse <= 1'b1;
              if (next_q == 32'd0) begin
                eoc_pulse <= 1'b1;
                st        <= ST_IDLE;
              end else begin
                cur_desc <= next_q;
                hidx     <= HW'(HDR_CMD);
                st       <= ST_HDR;
              end
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/xce_chan.sv
module xce_chan
  import xce_pkg::*;
#(
  parameter int unsigned NSRC = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  input  logic        mem_rerr,
  output logic        eod_pulse,
  output logic        eoc_pulse
);
  logic        busy, start, mode_xor;
  logic [31:0] cur_desc, err_addr, next_ptr;

  xce_regs u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .busy(busy), .cur_desc(cur_desc),
    .err_addr(err_addr), .reg_rdata(reg_rdata), .start(start),
    .next_ptr(next_ptr), .mode_xor(mode_xor)
  );

  xce_walker #(.NSRC(NSRC)) u_walk (
    .clk(clk), .rst(rst), .start(start), .start_ptr(next_ptr),
    .mode_xor(mode_xor), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .mem_rerr(mem_rerr), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .eod_pulse(eod_pulse),
    .eoc_pulse(eoc_pulse), .busy(busy), .cur_desc(cur_desc),
    .err_addr(err_addr)
  );
endmodule

// File: rtl/xce_chan_chk.sv
module xce_chan_chk (
  input logic clk,
  input logic rst,
  input logic mem_req,
  input logic mem_rvalid,
  input logic mem_rerr,
  input logic eod_pulse,
  input logic eoc_pulse,
  input logic busy,
  input logic start
);
  logic outstanding;

  always_ff @(posedge clk) begin
    if (rst) outstanding <= 1'b0;
    else     outstanding <= (outstanding | mem_req) & ~mem_rvalid;
  end

  p_req_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);

  p_one_outstanding_r11: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !outstanding);

  p_quiet_when_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req);

  p_start_source_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  p_eod_single_r6: assert property (@(posedge clk) disable iff (rst)
    eod_pulse |=> !eod_pulse);

  p_eoc_with_eod_r7: assert property (@(posedge clk) disable iff (rst)
    eoc_pulse |-> eod_pulse);

  p_abort_idle_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && mem_rvalid && mem_rerr) |=> !busy);
endmodule

bind xce_chan xce_chan_chk u_chk (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_rvalid(mem_rvalid),
  .mem_rerr(mem_rerr), .eod_pulse(eod_pulse), .eoc_pulse(eoc_pulse),
  .busy(busy), .start(start)
);

// File: tb/tb_xce_chan.sv
module tb_xce_chan;
  localparam int unsigned SRC_BASE = 32'h400;
  localparam int unsigned WDOG     = 100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        mem_rerr = 1'b0;
  logic        eod_pulse, eoc_pulse;

  int errors = 0;
  int checks = 0;
  int eod_cnt = 0;
  int eoc_cnt = 0;
  int cycles = 0;

  logic [31:0] mem [0:1023];
  int          exp_q [$];

  bit          err_on = 1'b0;
  logic [31:0] err_at = '0;
  bit          pend = 1'b0, pend_err = 1'b0, lat = 1'b0;
  int          wcnt = 0;
  logic [31:0] pend_data = '0;

  always #10 clk = ~clk;

  xce_chan dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_rerr(mem_rerr),
    .eod_pulse(eod_pulse), .eoc_pulse(eoc_pulse)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: latency alternates between 0 and 1 extra cycles
  always @(negedge clk) begin
    if (rst) begin
      pend = 1'b0;
      mem_rvalid = 1'b0;
      mem_rerr = 1'b0;
    end else begin
      mem_rvalid = 1'b0;
      mem_rerr = 1'b0;
      if (mem_req) begin
        pend_err = err_on && (mem_addr == err_at);
        pend_data = '0;
        if (!pend_err) begin
          if (mem_we) mem[mem_addr[11:2]] = mem_wdata;
          else        pend_data = mem[mem_addr[11:2]];
        end
        pend = 1'b1;
        wcnt = int'(lat);
        lat = ~lat;
      end
      if (pend) begin
        if (wcnt == 0) begin
          mem_rvalid = 1'b1;
          mem_rdata = pend_data;
          mem_rerr = pend_err;
          pend = 1'b0;
        end else begin
          wcnt--;
        end
      end
    end
  end

  // per-clock reference: completion order and status marking
  always @(negedge clk) begin
    if (!rst) begin
      if (eod_pulse) begin
        eod_cnt++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 unexpected end of descriptor", 32'd1, 32'd0);
        end else begin
          int a;
          a = exp_q.pop_front();
          check(mem[a[11:2]] == 32'h8000_0000, "R6 status word", mem[a[11:2]],
                32'h8000_0000);
        end
      end
      if (eoc_pulse) begin
        eoc_cnt++;
        check(eod_pulse && exp_q.size() == 0, "R7 end of chain timing",
              32'(exp_q.size()), 32'd0);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == WDOG) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected<%0d", cycles, WDOG);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [31:0] pat(input int i, input int w);
    return 32'h1357_9BDF * (i + 1) + w * 32'h0101_0001;
  endfunction

  function automatic logic [31:0] ref_word(input bit xm, input logic [7:0] en,
                                           input int w);
    logic [31:0] r;
    if (!xm) return pat(0, w);
    r = '0;
    for (int i = 0; i < 8; i++) if (en[i]) r ^= pat(i, w);
    return r;
  endfunction

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    int n = 0;
    do begin
      rd_reg(3'd0, v);
      n++;
    end while (v[5:4] != 2'd0 && n < 5000);
    check(n < 5000, "R2 channel returns idle", v, 32'd0);
  endtask

  task automatic put_desc(input int base, input logic [31:0] cmd,
                          input logic [31:0] nxt, input logic [31:0] cnt,
                          input logic [31:0] dst);
    mem[base/4]     = 32'd0;
    mem[base/4 + 1] = cmd;
    mem[base/4 + 2] = nxt;
    mem[base/4 + 3] = cnt;
    mem[base/4 + 4] = dst;
    for (int i = 0; i < 8; i++) mem[base/4 + 5 + i] = SRC_BASE + i * 64;
  endtask

  task automatic fill(input int dst, input int words, input logic [31:0] v);
    for (int w = 0; w < words; w++) mem[dst/4 + w] = v;
  endtask

  initial begin
    logic [31:0] v;
    int e0, c0;
    for (int k = 0; k < 1024; k++) mem[k] = '0;
    for (int i = 0; i < 8; i++)
      for (int w = 0; w < 16; w++) mem[(SRC_BASE + i * 64) / 4 + w] = pat(i, w);

    repeat (5) @(negedge clk);
    rst = 1'b0;
    check(!eod_pulse && !eoc_pulse && !mem_req, "R11 reset outputs quiet",
          {29'd0, eod_pulse, eoc_pulse, mem_req}, 32'd0);
    rd_reg(3'd0, v);
    check(v[5:4] == 2'd0, "R2 idle after reset", v, 32'd0);

    // R1: activation write with bit 0 clear is ignored
    put_desc(32'h100, 32'h8000_0000, 0, 12, 32'h800);
    wr_reg(3'd1, 32'h100);
    wr_reg(3'd0, 32'h0);
    repeat (4) @(negedge clk);
    rd_reg(3'd0, v);
    check(v[5:4] == 2'd0 && eod_cnt == 0, "R1 start bit clear ignored", v, 32'd0);

    // R4: copy mode, enable bits all clear still copies source 0
    wr_reg(3'd3, 32'd0);
    exp_q.push_back(32'h100);
    wr_reg(3'd0, 32'd1);
    @(negedge clk);
    rd_reg(3'd0, v);
    check(v[5:4] == 2'd1, "R2 active while walking", v, 32'h10);
    wait_idle();
    for (int w = 0; w < 3; w++)
      check(mem[32'h800/4 + w] == ref_word(0, 8'h00, w), "R4 copy word",
            mem[32'h800/4 + w], ref_word(0, 8'h00, w));
    check(mem[32'h800/4 + 3] == 32'd0, "R4 copy stops at count",
          mem[32'h800/4 + 3], 32'd0);
    rd_reg(3'd2, v);
    check(v == 32'h100, "R8 current descriptor", v, 32'h100);
    check(eoc_cnt == 1 && eod_cnt == 1, "R7 single-descriptor chain",
          32'(eoc_cnt), 32'd1);

    // R5/R9/R7: two-descriptor XOR chain, mode rewritten mid-chain
    put_desc(32'h140, 32'h8000_00A5, 32'h180, 16, 32'h880);
    put_desc(32'h180, 32'h8000_0080, 32'h0, 8, 32'h900);
    wr_reg(3'd3, 32'd1);
    wr_reg(3'd1, 32'h140);
    exp_q.push_back(32'h140);
    exp_q.push_back(32'h180);
    wr_reg(3'd0, 32'd1);
    wr_reg(3'd3, 32'd0);
    wait_idle();
    for (int w = 0; w < 4; w++)
      check(mem[32'h880/4 + w] == ref_word(1, 8'hA5, w), "R5 xor of enabled sources",
            mem[32'h880/4 + w], ref_word(1, 8'hA5, w));
    for (int w = 0; w < 2; w++)
      check(mem[32'h900/4 + w] == ref_word(1, 8'h80, w), "R9 mode held for chain",
            mem[32'h900/4 + w], ref_word(1, 8'h80, w));
    rd_reg(3'd2, v);
    check(v == 32'h180, "R8 current is last processed", v, 32'h180);
    check(eod_cnt == 3 && eoc_cnt == 2, "R7 chain followed next pointer",
          32'(eod_cnt), 32'd3);

    // R5: XOR with no source enabled writes zero
    put_desc(32'h1C0, 32'h8000_0000, 0, 8, 32'h980);
    fill(32'h980, 2, 32'hFFFF_FFFF);
    wr_reg(3'd3, 32'd1);
    wr_reg(3'd1, 32'h1C0);
    exp_q.push_back(32'h1C0);
    wr_reg(3'd0, 32'd1);
    wait_idle();
    check(mem[32'h980/4] == 32'd0 && mem[32'h980/4 + 1] == 32'd0,
          "R5 no sources gives zero", mem[32'h980/4], 32'd0);

    // R3: command without valid bit aborts
    put_desc(32'h100, 32'h0000_0001, 0, 8, 32'hA00);
    fill(32'hA00, 2, 32'h5555_AAAA);
    e0 = eod_cnt; c0 = eoc_cnt;
    wr_reg(3'd1, 32'h100);
    wr_reg(3'd0, 32'd1);
    wait_idle();
    rd_reg(3'd4, v);
    check(v == 32'h100, "R3 invalid command error address", v, 32'h100);
    check(mem[32'hA00/4] == 32'h5555_AAAA, "R3 no data written",
          mem[32'hA00/4], 32'h5555_AAAA);
    check(mem[32'h100/4] == 32'd0 && eod_cnt == e0 && eoc_cnt == c0,
          "R3 no completion", mem[32'h100/4], 32'd0);

    // R10: error response on third source word aborts mid-descriptor
    put_desc(32'h140, 32'h8000_0001, 32'h180, 16, 32'hA80);
    fill(32'hA80, 4, 32'hDEAD_BEEF);
    wr_reg(3'd3, 32'd0);
    err_at = SRC_BASE + 8;
    err_on = 1'b1;
    e0 = eod_cnt; c0 = eoc_cnt;
    wr_reg(3'd1, 32'h140);
    wr_reg(3'd0, 32'd1);
    wait_idle();
    err_on = 1'b0;
    rd_reg(3'd4, v);
    check(v == SRC_BASE + 8, "R10 failing address recorded", v, SRC_BASE + 8);
    check(mem[32'hA80/4] == pat(0, 0) && mem[32'hA80/4 + 1] == pat(0, 1),
          "R10 words before error written", mem[32'hA80/4 + 1], pat(0, 1));
    check(mem[32'hA80/4 + 2] == 32'hDEAD_BEEF && mem[32'hA80/4 + 3] == 32'hDEAD_BEEF,
          "R10 words after error untouched", mem[32'hA80/4 + 2], 32'hDEAD_BEEF);
    check(mem[32'h140/4] == 32'd0 && eod_cnt == e0 && eoc_cnt == c0,
          "R10 no status and no pulses", mem[32'h140/4], 32'd0);
    rd_reg(3'd2, v);
    check(v == 32'h140, "R8 current after abort", v, 32'h140);
    check(exp_q.size() == 0, "R6 every expected descriptor completed",
          32'(exp_q.size()), 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule